// File: doc/BRIEF.md
# Microcoded Control Unit for a Multicycle Processor

This block sequences the datapath of a multicycle 32-bit processor. Control lives in a small read-only store: every control state is one stored word, and the state's code is that word's address. Each word carries the datapath control fields and a two-bit sequencing field. The sequencing field picks the next address in one of four ways: the following word, back to instruction fetch, or a jump through one of two opcode-indexed dispatch tables.

The unit executes register-format ALU operations, load word, store word, branch-if-equal, jump and jump-register. Jump-register uses opcode 7, which the rest of the subset leaves free. The store's read is registered, so every control output comes from a flop, and a synchronous active-high reset returns the unit to the fetch word. The opcode input must come from the instruction register. It is sampled only in the decode cycle and in the shared memory-address cycle.

Top module: `ucode_ctrl`

## Requirements
- R1: In the first cycle after reset is released, the outputs show the fetch word: mem_rd=1, addr_sel=0, ir_wr=1, alu_a=0, alu_b=01, alu_op=00, pc_wr=1, pc_src=00, and every other output is 0.
- R2: The decode word always follows fetch. In decode, alu_a=0, alu_b=11 and alu_op=00, and every write enable and memory strobe is 0.
- R3: Load word (opcode 35) takes 5 cycles: fetch, decode, address (alu_a=1, alu_b=10, alu_op=00), memory read (mem_rd=1, addr_sel=1), then write-back (reg_wr=1, mem_to_reg=1, reg_dst=0).
- R4: Store word (opcode 43) takes 4 cycles: fetch, decode, the same address word as R3, then mem_wr=1 with addr_sel=1.
- R5: Register-format (opcode 0) takes 4 cycles: fetch, decode, execute (alu_a=1, alu_b=00, alu_op=10), then write-back (reg_wr=1, reg_dst=1, mem_to_reg=0).
- R6: Branch-if-equal (opcode 4) takes 3 cycles. Its last word has pc_wr_cond=1, pc_src=01, alu_a=1, alu_b=00 and alu_op=01.
- R7: Jump (opcode 2) takes 3 cycles. Its last word has pc_wr=1 and pc_src=10.
- R8: Jump-register (opcode 7) takes 3 cycles. Its last word has pc_wr=1 and pc_src=11.
- R9: Any other opcode runs only fetch and decode, and then fetch follows. The decode cycle asserts no write enable and no memory strobe.
- R10: Every output that the current word does not set reads 0. mem_rd and mem_wr are never both 1.
- R11: A reset asserted in the middle of an instruction brings back the fetch word in the first cycle after release.
- R12: The opcode has no effect in cycles other than decode and address. A different opcode present during fetch or execute does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU reports equal |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU result |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data source: 1 = memory data |
| reg_wr | output | 1 | Register file write enable |
| reg_dst | output | 1 | Destination register select: 1 = rd field |
| alu_a | output | 1 | First ALU operand: 0 = PC, 1 = register A |
| alu_b | output | 2 | Second ALU operand: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU register, 10 jump target, 11 register rs |

## Verification
The hardest case to reach from the ports is a reset that lands partway through a multi-word instruction. It must discard the sequencer's position and the pending word together. The bench starts a load, stops at its address word, pulses reset there, and then checks both the fetch word and a complete load that follows. It also shows that the opcode is sampled only at the two dispatch points. To do so, it presents a store opcode during fetch and a load opcode during the write-back of a register-format instruction, and compares every cycle against its own per-instruction expectation lists.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  typedef enum logic [1:0] {
    SEQ_NEXT  = 2'b00,
    SEQ_FETCH = 2'b01,
    SEQ_DISP1 = 2'b10,
    SEQ_DISP2 = 2'b11
  } seq_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       mem_to_reg;
    logic       reg_wr;
    logic       reg_dst;
    logic       alu_a;
    logic [1:0] alu_b;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    seq_e       seq;
  } uword_t;

  localparam logic [5:0] OP_RFMT  = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_JMP   = 6'd2;
  localparam logic [5:0] OP_JREG  = 6'd7;

  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_MADDR  = 2;
  localparam int UA_LDMEM  = 3;
  localparam int UA_LDWB   = 4;
  localparam int UA_STMEM  = 5;
  localparam int UA_REXE   = 6;
  localparam int UA_RWB    = 7;
  localparam int UA_BEQ    = 8;
  localparam int UA_JMP    = 9;
  localparam int UA_JREG   = 10;

  // Microprogram contents; every field not set stays 0.
  function automatic uword_t ucode_word(input int a);
    uword_t w;
    w     = '0;
    w.seq = SEQ_FETCH;
    case (a)
      UA_FETCH: begin
        w.mem_rd = 1'b1; w.ir_wr = 1'b1; w.alu_b = 2'b01;
        w.pc_wr  = 1'b1; w.seq   = SEQ_NEXT;
      end
      UA_DECODE: begin
        w.alu_b = 2'b11; w.seq = SEQ_DISP1;
      end
      UA_MADDR: begin
        w.alu_a = 1'b1; w.alu_b = 2'b10; w.seq = SEQ_DISP2;
      end
      UA_LDMEM: begin
        w.mem_rd = 1'b1; w.addr_sel = 1'b1; w.seq = SEQ_NEXT;
      end
      UA_LDWB: begin
        w.reg_wr = 1'b1; w.mem_to_reg = 1'b1;
      end
      UA_STMEM: begin
        w.mem_wr = 1'b1; w.addr_sel = 1'b1;
      end
      UA_REXE: begin
        w.alu_a = 1'b1; w.alu_op = 2'b10; w.seq = SEQ_NEXT;
      end
      UA_RWB: begin
        w.reg_wr = 1'b1; w.reg_dst = 1'b1;
      end
      UA_BEQ: begin
        w.alu_a = 1'b1; w.alu_op = 2'b01; w.pc_wr_cond = 1'b1;
        w.pc_src = 2'b01;
      end
      UA_JMP: begin
        w.pc_wr = 1'b1; w.pc_src = 2'b10;
      end
      UA_JREG: begin
        w.pc_wr = 1'b1; w.pc_src = 2'b11;
      end
      default: w.seq = SEQ_FETCH;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output uword_t        word
);

  localparam int DEPTH = 1 << AW;

  uword_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign tbl[g] = ucode_word(g);
  end

  // Registered read so the store maps onto a synchronous memory.
  always_ff @(posedge clk) begin
    word <= tbl[addr];
  end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int AW   = 4,
  parameter int OP_W = 6
) (
  input  logic          rst,
  input  logic [AW-1:0] cur_addr,
  input  seq_e          seq,
  input  logic [OP_W-1:0] opcode,
  output logic [AW-1:0] next_addr
);

  logic [AW-1:0] disp1_tgt;
  logic [AW-1:0] disp2_tgt;

  // Table 1: decode to first execute word.
  always_comb begin
    case (opcode)
      OP_W'(OP_RFMT):  disp1_tgt = AW'(UA_REXE);
      OP_W'(OP_LOAD):  disp1_tgt = AW'(UA_MADDR);
      OP_W'(OP_STORE): disp1_tgt = AW'(UA_MADDR);
      OP_W'(OP_BEQ):   disp1_tgt = AW'(UA_BEQ);
      OP_W'(OP_JMP):   disp1_tgt = AW'(UA_JMP);
      OP_W'(OP_JREG):  disp1_tgt = AW'(UA_JREG);
      default:         disp1_tgt = AW'(UA_FETCH);
    endcase
  end

  // Table 2: shared address word to load or store access.
  always_comb begin
    case (opcode)
      OP_W'(OP_LOAD):  disp2_tgt = AW'(UA_LDMEM);
      OP_W'(OP_STORE): disp2_tgt = AW'(UA_STMEM);
      default:         disp2_tgt = AW'(UA_FETCH);
    endcase
  end

  always_comb begin
    if (rst) begin
      next_addr = AW'(UA_FETCH);
    end else begin
      case (seq)
        SEQ_NEXT:  next_addr = cur_addr + AW'(1);
        SEQ_FETCH: next_addr = AW'(UA_FETCH);
        SEQ_DISP1: next_addr = disp1_tgt;
        default:   next_addr = disp2_tgt;
      endcase
    end
  end

endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_pkg::*;
#(
  parameter int UADDR_W = 4,
  parameter int OP_W    = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            addr_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            mem_to_reg,
  output logic            reg_wr,
  output logic            reg_dst,
  output logic            alu_a,
  output logic [1:0]      alu_b,
  output logic [1:0]      alu_op,
  output logic [1:0]      pc_src
);

  logic [UADDR_W-1:0] upc_q;
  logic [UADDR_W-1:0] upc_next;
  uword_t             word_q;

  ucode_seq #(.AW(UADDR_W), .OP_W(OP_W)) i_seq (
    .rst       (rst),
    .cur_addr  (upc_q),
    .seq       (word_q.seq),
    .opcode    (opcode),
    .next_addr (upc_next)
  );

  ucode_rom #(.AW(UADDR_W)) i_rom (
    .clk  (clk),
    .addr (upc_next),
    .word (word_q)
  );

  // Address register moves in step with the registered store output.
  always_ff @(posedge clk) begin
    upc_q <= upc_next;
  end

  assign pc_wr      = word_q.pc_wr;
  assign pc_wr_cond = word_q.pc_wr_cond;
  assign addr_sel   = word_q.addr_sel;
  assign mem_rd     = word_q.mem_rd;
  assign mem_wr     = word_q.mem_wr;
  assign ir_wr      = word_q.ir_wr;
  assign mem_to_reg = word_q.mem_to_reg;
  assign reg_wr     = word_q.reg_wr;
  assign reg_dst    = word_q.reg_dst;
  assign alu_a      = word_q.alu_a;
  assign alu_b      = word_q.alu_b;
  assign alu_op     = word_q.alu_op;
  assign pc_src     = word_q.pc_src;

endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic       reg_wr,
  input logic [1:0] alu_b,
  input logic [1:0] pc_src
);

  AST_RESET_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_wr && mem_rd && pc_wr && !addr_sel)); // R11

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (!ir_wr && alu_b == 2'b11)); // R2

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R10

  AST_WRITEBACK_ENDS: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> ir_wr); // R3

  AST_STORE_ENDS: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_wr); // R4

  AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_wr); // R6

  AST_JREG_ENDS: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_src == 2'b11) |=> ir_wr); // R8

endmodule

bind ucode_ctrl ucode_ctrl_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .pc_wr      (pc_wr),
  .pc_wr_cond (pc_wr_cond),
  .addr_sel   (addr_sel),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .ir_wr      (ir_wr),
  .reg_wr     (reg_wr),
  .alu_b      (alu_b),
  .pc_src     (pc_src)
);

// File: tb/test_ucode_ctrl.sv
module test_ucode_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
  logic mem_to_reg, reg_wr, reg_dst, alu_a;
  logic [1:0] alu_b, alu_op, pc_src;
  logic [15:0] act;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  ucode_ctrl i_ucode_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .mem_to_reg(mem_to_reg), .reg_wr(reg_wr), .reg_dst(reg_dst),
    .alu_a(alu_a), .alu_b(alu_b), .alu_op(alu_op), .pc_src(pc_src)
  );

  assign act = {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr,
                mem_to_reg, reg_wr, reg_dst, alu_a, alu_b, alu_op, pc_src};

  function automatic logic [15:0] mkv(
    input logic pw, pwc, asel, mr, mw, iw, m2r, rw, rd, aa,
    input logic [1:0] ab, ao, ps);
    return {pw, pwc, asel, mr, mw, iw, m2r, rw, rd, aa, ab, ao, ps};
  endfunction

  // Expected words, from the requirements.
  localparam logic [15:0] V_FETCH = mkv(1,0,0,1,0,1,0,0,0,0,2'b01,2'b00,2'b00);
  localparam logic [15:0] V_DEC   = mkv(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00);
  localparam logic [15:0] V_MADDR = mkv(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00);
  localparam logic [15:0] V_LDMEM = mkv(0,0,1,1,0,0,0,0,0,0,2'b00,2'b00,2'b00);
  localparam logic [15:0] V_LDWB  = mkv(0,0,0,0,0,0,1,1,0,0,2'b00,2'b00,2'b00);
  localparam logic [15:0] V_STMEM = mkv(0,0,1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00);
  localparam logic [15:0] V_REXE  = mkv(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00);
  localparam logic [15:0] V_RWB   = mkv(0,0,0,0,0,0,0,1,1,0,2'b00,2'b00,2'b00);
  localparam logic [15:0] V_BEQ   = mkv(0,1,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01);
  localparam logic [15:0] V_JMP   = mkv(1,0,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10);
  localparam logic [15:0] V_JREG  = mkv(1,0,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b11);

  task automatic check(input string req, input logic [15:0] a, input logic [15:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, a, e);
    end
  endtask

  // Reference model: per-instruction list of control words.
  task automatic run_instr(input logic [5:0] op, input string req, input bit scramble);
    logic [15:0] q[$];
    q = '{V_FETCH, V_DEC};
    case (op)
      6'd35: q = '{V_FETCH, V_DEC, V_MADDR, V_LDMEM, V_LDWB};
      6'd43: q = '{V_FETCH, V_DEC, V_MADDR, V_STMEM};
      6'd0:  q = '{V_FETCH, V_DEC, V_REXE, V_RWB};
      6'd4:  q = '{V_FETCH, V_DEC, V_BEQ};
      6'd2:  q = '{V_FETCH, V_DEC, V_JMP};
      6'd7:  q = '{V_FETCH, V_DEC, V_JREG};
      default: ;
    endcase
    opcode = scramble ? 6'd43 : op;
    for (int i = 0; i < q.size(); i++) begin
      if (i == 1) opcode = op;
      if (scramble && i == 3) opcode = 6'd35;
      check(req, act, q[i]);
      @(posedge clk);
      @(negedge clk);
    end
    // Cycle count: fetch must return exactly after the listed words.
    check({req, " length"}, act, V_FETCH);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", act, V_FETCH);

    run_instr(6'd35, "R3 load/R2", 1'b0);
    run_instr(6'd43, "R4 store", 1'b0);
    run_instr(6'd0,  "R5 rformat", 1'b0);
    run_instr(6'd4,  "R6 branch/R10", 1'b0);
    run_instr(6'd2,  "R7 jump/R10", 1'b0);
    run_instr(6'd7,  "R8 jreg", 1'b0);
    run_instr(6'd63, "R9 unknown", 1'b0);
    run_instr(6'd5,  "R9 unknown", 1'b0);
    run_instr(6'd0,  "R12 opcode ignored", 1'b1);
    run_instr(6'd4,  "R12 after scramble", 1'b0);

    // Reset in the middle of a load, at its address word.
    opcode = 6'd35;
    check("R11 pre fetch", act, V_FETCH);
    @(posedge clk); @(negedge clk);
    check("R11 pre decode", act, V_DEC);
    @(posedge clk); @(negedge clk);
    check("R11 pre address", act, V_MADDR);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R11 fetch after reset", act, V_FETCH);
    run_instr(6'd35, "R11 load after reset", 1'b0);
    run_instr(6'd7,  "R8 jreg again", 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule